// File: doc/BRIEF.md
# Graded Inhibition Gate with Sine Sigmoid

This block computes the analog response of one excitation/inhibition cell in fixed point. It takes an excitatory value and an inhibitory value, both unsigned fractions. Each one is bent through a half-period sine curve that rises from 0 to 1. The result is the first curved value minus the second, and any negative result becomes zero.

Because the curve is flat at both ends, inputs that sit close to clean 0 or clean 1 move closer to those values. For example, a slightly noisy "high, low" pair gives an output above the plain difference. Inputs near the other three binary pairs give an output below the plain difference, or zero. With the excitatory input held at full scale, the block acts as a graded inverter of the inhibitory input.

The block accepts one operand pair per clock and returns results in issue order after a fixed delay. A valid flag travels alongside the data. The sine curve is stored in a table of 257 knots that is computed at elaboration time. The four low input bits interpolate linearly between neighbouring knots.

Top module: `anot_unit`

## Requirements
- R1: With binary operands, where code 0 means 0.0 and code 4095 means 1.0, the result is 4095 only for excitation 4095 with inhibition 0. The other three binary pairs give exactly 0.
- R2: For any operands, the result is within 2 LSB of 4095·max(0, s(X) − s(Y)). Here s(v) = 0.5·sin(π(v − 0.5)) + 0.5, and v is the input code divided by 4095.
- R3: Near the pair (4095, 0), the result in codes is larger than X − Y. Near (0, 0) and (4095, 4095), it is smaller than X − Y.
- R4: Whenever the inhibition code is greater than or equal to the excitation code, the result is exactly 0.
- R5: With excitation tied to 4095, the result follows 4095·(1 − s(Y)) within 2 LSB. This runs from 4095 at Y = 0 down to 0 at Y = 4095.
- R6: out_valid equals in_valid delayed by exactly 3 clocks. Operands may arrive on every clock or with gaps, and each result appears exactly 3 clocks after its operands.
- R7: While rst_n is low, out_valid and out_resp are 0 whatever the inputs do. After reset is released, out_valid stays 0 until 3 clocks after the first operand.
- R8: For a fixed inhibition, the result never decreases as the excitation code rises. The same holds inside the block: each interpolated curve value lies between its two table knots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_excite | input | 12 | Excitatory operand, code 4095 = 1.0 |
| in_inhibit | input | 12 | Inhibitory operand, code 4095 = 1.0 |
| out_valid | output | 1 | Result present this cycle |
| out_resp | output | 12 | Graded response, code 4095 = 1.0 |

## Verification
The assertions check the following on every clock:
- the three-cycle valid alignment;
- the zero result whenever inhibition is at least as large as excitation, both at the subtract stage and at the ports;
- the exact binary corners against the operands carried down the pipe;
- that every interpolated curve value stays between its knots.

The accuracy of the sine shape against a real-valued model, the direction of the pull near each corner, the inverter sweep and the monotonic rise over a sweep are visible only in the bench's scenarios.

// File: rtl/anot_pkg.sv
package anot_pkg;

  localparam int ANOT_DATA_W     = 12;
  localparam int ANOT_INDEX_W    = 8;
  localparam int ANOT_GUARD_W    = 4;
  localparam int ANOT_PIPE_DEPTH = 3;
  localparam real ANOT_PI        = 3.14159265358979323846;

  // Half-period sine curve: 0 at pos=0, 1 at pos=1.
  function automatic real sine_sigmoid(real pos);
    return 0.5 * $sin(ANOT_PI * (pos - 0.5)) + 0.5;
  endfunction

  // Knot k of the curve, scaled to full-scale code times 2**gw, rounded.
  function automatic int knot_level(int k, int dw, int iw, int gw);
    real full;
    real pos;
    real top;
    real lvl;
    full = real'((longint'(1) << dw) - 1);
    pos  = real'(longint'(k) << (dw - iw)) / full;
    if (pos > 1.0) pos = 1.0;
    top  = full * real'(longint'(1) << gw);
    lvl  = sine_sigmoid(pos) * top + 0.5;
    if (lvl > top) lvl = top;
    if (lvl < 0.0) lvl = 0.0;
    return $rtoi(lvl);
  endfunction

endpackage

// File: rtl/anot_sig_table.sv
module anot_sig_table
  import anot_pkg::*;
#(
  parameter  int DATA_W  = ANOT_DATA_W,
  parameter  int INDEX_W = ANOT_INDEX_W,
  parameter  int GUARD_W = ANOT_GUARD_W,
  localparam int LEVEL_W = DATA_W + GUARD_W
) (
  input  logic [INDEX_W-1:0] seg,
  output logic [LEVEL_W-1:0] level_lo,
  output logic [LEVEL_W-1:0] level_hi
);

  localparam int KNOTS = (1 << INDEX_W) + 1;

  logic [LEVEL_W-1:0] knot [KNOTS];
  logic [INDEX_W:0]   seg_next;

  // One extra knot at the top so the upper neighbour always exists.
  genvar k;
  generate
    for (k = 0; k < KNOTS; k++) begin : g_knot
      localparam int LV = knot_level(k, DATA_W, INDEX_W, GUARD_W);
      assign knot[k] = LEVEL_W'(LV);
    end
  endgenerate

  assign seg_next = {1'b0, seg} + 1'b1;
  assign level_lo = knot[seg];
  assign level_hi = knot[seg_next];

endmodule

// File: rtl/anot_sig_lane.sv
module anot_sig_lane
  import anot_pkg::*;
#(
  parameter  int DATA_W  = ANOT_DATA_W,
  parameter  int INDEX_W = ANOT_INDEX_W,
  parameter  int GUARD_W = ANOT_GUARD_W,
  localparam int LEVEL_W = DATA_W + GUARD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  code,
  output logic [LEVEL_W-1:0] level
);

  localparam int FRAC_W = DATA_W - INDEX_W;
  localparam int PROD_W = LEVEL_W + FRAC_W;

  logic [LEVEL_W-1:0] tab_lo, tab_hi;
  logic [LEVEL_W-1:0] lo_q, hi_q;
  logic [FRAC_W-1:0]  frac_q;
  logic [LEVEL_W-1:0] level_q;

  // Linear blend between knots, rounded to nearest guard unit.
  function automatic logic [LEVEL_W-1:0] blend(
    input logic [LEVEL_W-1:0] lo,
    input logic [LEVEL_W-1:0] hi,
    input logic [FRAC_W-1:0]  frac
  );
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(hi - lo) * PROD_W'(frac) + PROD_W'(1 << (FRAC_W - 1));
    return lo + LEVEL_W'(prod >> FRAC_W);
  endfunction

  anot_sig_table #(
    .DATA_W (DATA_W),
    .INDEX_W(INDEX_W),
    .GUARD_W(GUARD_W)
  ) u_table (
    .seg     (code[DATA_W-1 -: INDEX_W]),
    .level_lo(tab_lo),
    .level_hi(tab_hi)
  );

  // Stage 1: table read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      frac_q <= '0;
    end else begin
      lo_q   <= tab_lo;
      hi_q   <= tab_hi;
      frac_q <= code[FRAC_W-1:0];
    end
  end

  // Stage 2: interpolation
  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= blend(lo_q, hi_q, frac_q);
  end

  assign level = level_q;

  // R8: knots rise along the curve
  assert_table_rising_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q >= lo_q);

  // R8: interpolated level sits between the knots it came from
  assert_interp_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q >= $past(lo_q)) && (level_q <= $past(hi_q)));

endmodule

// File: rtl/anot_resp_stage.sv
module anot_resp_stage
  import anot_pkg::*;
#(
  parameter  int DATA_W  = ANOT_DATA_W,
  parameter  int GUARD_W = ANOT_GUARD_W,
  localparam int LEVEL_W = DATA_W + GUARD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] level_exc,
  input  logic [LEVEL_W-1:0] level_inh,
  output logic [DATA_W-1:0]  resp
);

  localparam int              SUM_W = LEVEL_W + 1;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1 << (GUARD_W - 1));
  localparam logic [SUM_W-1:0] TOP  = SUM_W'((1 << DATA_W) - 1);

  logic               inhibit_wins;
  logic [DATA_W-1:0]  resp_q;

  // Floor at zero, round away the guard bits, saturate to full scale.
  function automatic logic [DATA_W-1:0] settle(
    input logic [LEVEL_W-1:0] exc,
    input logic [LEVEL_W-1:0] inh
  );
    logic [SUM_W-1:0] margin;
    logic [SUM_W-1:0] scaled;
    if (exc <= inh) return '0;
    margin = {1'b0, exc - inh} + HALF;
    scaled = margin >> GUARD_W;
    if (scaled > TOP) return DATA_W'(TOP);
    return DATA_W'(scaled);
  endfunction

  assign inhibit_wins = (level_inh >= level_exc);

  always_ff @(posedge clk) begin
    if (!rst_n) resp_q <= '0;
    else        resp_q <= settle(level_exc, level_inh);
  end

  assign resp = resp_q;

  // R4: an inhibition level at least as large forces a zero result
  assert_inhibit_dominates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_wins |=> (resp_q == '0));

endmodule

// File: rtl/anot_unit.sv
module anot_unit
  import anot_pkg::*;
#(
  parameter int DATA_W  = ANOT_DATA_W,
  parameter int INDEX_W = ANOT_INDEX_W,
  parameter int GUARD_W = ANOT_GUARD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_excite,
  input  logic [DATA_W-1:0] in_inhibit,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_resp
);

  localparam int               LEVEL_W = DATA_W + GUARD_W;
  localparam int               LANES   = 2;
  localparam int               DEPTH   = ANOT_PIPE_DEPTH;
  localparam logic [DATA_W-1:0] FULL   = '1;

  logic [DATA_W-1:0]  lane_code  [LANES];
  logic [LEVEL_W-1:0] lane_level [LANES];
  logic [DEPTH-1:0]   valid_pipe;
  logic [DATA_W-1:0]  exc_tap [DEPTH];
  logic [DATA_W-1:0]  inh_tap [DEPTH];
  logic [1:0]         since_rst;

  assign lane_code[0] = in_excite;
  assign lane_code[1] = in_inhibit;

  // Lane 0 bends the excitation, lane 1 the inhibition.
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      anot_sig_lane #(
        .DATA_W (DATA_W),
        .INDEX_W(INDEX_W),
        .GUARD_W(GUARD_W)
      ) u_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .code (lane_code[g]),
        .level(lane_level[g])
      );
    end
  endgenerate

  anot_resp_stage #(
    .DATA_W (DATA_W),
    .GUARD_W(GUARD_W)
  ) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_exc(lane_level[0]),
    .level_inh(lane_level[1]),
    .resp     (out_resp)
  );

  // Valid travels beside the data, plus operand taps for the checks.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_pipe <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        exc_tap[i] <= '0;
        inh_tap[i] <= '0;
      end
    end else begin
      valid_pipe <= {valid_pipe[DEPTH-2:0], in_valid};
      exc_tap[0] <= in_excite;
      inh_tap[0] <= in_inhibit;
      for (int i = 1; i < DEPTH; i++) begin
        exc_tap[i] <= exc_tap[i-1];
        inh_tap[i] <= inh_tap[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != '1) since_rst <= since_rst + 2'd1;
  end

  assign out_valid = valid_pipe[DEPTH-1];

  // R6: valid out is valid in, three clocks late
  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, DEPTH)));

  // R1: full excitation with no inhibition reaches full scale
  assert_corner_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_tap[DEPTH-1] == FULL && inh_tap[DEPTH-1] == '0)
      |-> (out_resp == FULL));

  // R4: inhibition code at or above excitation code yields zero
  assert_ge_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && inh_tap[DEPTH-1] >= exc_tap[DEPTH-1]) |-> (out_resp == '0));

endmodule

// File: tb/anot_unit_tb.sv
`timescale 1ns/1ps
module anot_unit_tb;

  localparam real PI = 3.14159265358979323846;
  localparam int  QN = 1024;
  localparam int  NV = 16;

  // Vector table: excitation, inhibition, exact expectation (-1 = model), requirement
  localparam int VX [NV] = '{0, 0, 4095, 4095, 1000, 1000, 2047, 4095,
                             4095, 3000, 2500, 3500, 1500, 4000, 200, 3900};
  localparam int VY [NV] = '{0, 4095, 0, 4095, 1000, 3000, 2048, 2048,
                             1024, 1000, 2000, 500, 200, 3900, 100, 200};
  localparam int VE [NV] = '{0, 0, 4095, 0, 0, 0, 0, -1,
                             -1, -1, -1, -1, -1, -1, -1, -1};
  localparam int VR [NV] = '{1, 1, 1, 1, 4, 4, 4, 5,
                             5, 2, 2, 2, 2, 2, 2, 2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_excite = '0;
  logic [11:0] in_inhibit = '0;
  logic        out_valid;
  logic [11:0] out_resp;

  always #4 clk = ~clk;

  anot_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_excite (in_excite),
    .in_inhibit(in_inhibit),
    .out_valid (out_valid),
    .out_resp  (out_resp)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int q_x [QN];
  int q_y [QN];
  int q_e [QN];
  int q_r [QN];
  int q_c [QN];
  int wr_idx = 0;
  int rd_idx = 0;
  int last_resp = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real curve(int c);
    return 0.5 * $sin(PI * (real'(c) / 4095.0 - 0.5)) + 0.5;
  endfunction

  function automatic real model(int x, int y);
    real d;
    d = (curve(x) - curve(y)) * 4095.0;
    if (d < 0.0) d = 0.0;
    return d;
  endfunction

  function automatic bit near(int got, real m);
    return (real'(got) - m <= 2.0) && (m - real'(got) <= 2.0);
  endfunction

  task automatic note(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Result monitor: order, latency (R6) and value per queued operand pair
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (rd_idx >= wr_idx) note(1'b0, "R6", "result with no operands", 1, 0);
        else begin
          note(cyc == q_c[rd_idx] + 3, "R6", "latency", cyc - q_c[rd_idx], 3);
          if (q_e[rd_idx] >= 0)
            note(out_resp == q_e[rd_idx], $sformatf("R%0d", q_r[rd_idx]),
                 $sformatf("exact x=%0d y=%0d", q_x[rd_idx], q_y[rd_idx]),
                 out_resp, q_e[rd_idx]);
          else if (q_e[rd_idx] == -1)
            note(near(out_resp, model(q_x[rd_idx], q_y[rd_idx])),
                 $sformatf("R%0d", q_r[rd_idx]),
                 $sformatf("model x=%0d y=%0d", q_x[rd_idx], q_y[rd_idx]),
                 out_resp, $rtoi(model(q_x[rd_idx], q_y[rd_idx]) + 0.5));
          last_resp = out_resp;
          rd_idx++;
        end
      end else if (rd_idx < wr_idx && cyc >= q_c[rd_idx] + 3) begin
        note(1'b0, "R6", "missing result", 0, 1);
        rd_idx++;
      end
    end
  end

  task automatic issue(int x, int y, int e, int r);
    @(negedge clk);
    q_x[wr_idx] = x;
    q_y[wr_idx] = y;
    q_e[wr_idx] = e;
    q_r[wr_idx] = r;
    q_c[wr_idx] = cyc;
    wr_idx++;
    in_valid   = 1'b1;
    in_excite  = x[11:0];
    in_inhibit = y[11:0];
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    while (rd_idx != wr_idx) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic probe(int x, int y, output int got);
    issue(x, y, -2, 6);
    drain();
    got = last_resp;
  endtask

  initial begin
    int got;
    int prev;
    // R7: outputs stay low while reset is held, even with operands driven
    in_valid   = 1'b1;
    in_excite  = 12'd4095;
    in_inhibit = 12'd0;
    repeat (4) begin
      @(negedge clk);
      note(out_valid == 1'b0, "R7", "valid during reset", out_valid, 0);
      note(out_resp == 12'd0, "R7", "result during reset", out_resp, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    repeat (4) begin
      @(negedge clk);
      note(out_valid == 1'b0, "R7", "valid after reset, no operands", out_valid, 0);
    end

    // Vector table, back to back (R1, R2, R4, R5, R6)
    for (int i = 0; i < NV; i++) issue(VX[i], VY[i], VE[i], VR[i]);
    drain();

    // R6: operands with gaps keep their own three-cycle latency
    issue(4095, 0, 4095, 1);
    idle(2);
    issue(0, 4095, 0, 1);
    idle(1);
    issue(3000, 1000, -1, 2);
    drain();

    // Grid: zero when inhibition code >= excitation code (R4), model elsewhere (R2)
    for (int xi = 0; xi < 10; xi++)
      for (int yi = 0; yi < 10; yi++)
        if (yi >= xi) issue(xi * 455, yi * 455, 0, 4);
        else          issue(xi * 455, yi * 455, -1, 2);
    drain();

    // R5: excitation tied to full scale acts as a graded inverter
    for (int y = 0; y < 4096; y += 315) issue(4095, y, -1, 5);
    issue(4095, 4095, 0, 5);
    drain();

    // R3: pull toward clean binary values near the corners
    probe(3900, 200, got);
    note(got > 3700, "R3", "near (1,0) above X-Y", got, 3701);
    probe(3800, 100, got);
    note(got > 3700, "R3", "near (1,0) above X-Y", got, 3701);
    probe(200, 100, got);
    note(got < 100, "R3", "near (0,0) below X-Y", got, 99);
    probe(4000, 3900, got);
    note(got < 100, "R3", "near (1,1) below X-Y", got, 99);

    // R8: result never falls as excitation rises
    prev = 0;
    for (int x = 0; x <= 4095; x += 65) begin
      probe(x, 1500, got);
      note(got >= prev, "R8", $sformatf("monotone at x=%0d", x), got, prev);
      prev = got;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule